// File: doc/BRIEF.md
# Queued Serial Peripheral Interface Master

This block is a serial peripheral interface bus master that works through an eight-slot command queue without help from a processor. Each slot holds four things: a transmit word, the index of the peripheral select to drive low, a bit count from 1 to 16, and an idle delay. When a run is started, the engine executes the slots in index order. Each slot becomes one framed transfer on the serial clock, data-out and data-in lines. The bits shifted in during a frame are written back into the receive half of the same slot, where they can be read at any time.

Four active-low select lines are driven, never more than one at a time. The clock idle level (polarity) and the sampling edge (phase) are chosen when the run starts. The serial clock half-period is set in system clock cycles. In a one-shot run the engine halts after the last programmed slot and raises a sticky completion flag. In the looping mode it goes back to slot 0 after the last slot and keeps cycling until a stop request. The stop request takes effect at the end of the frame in progress.

Top module: `spi_queue_master`

## Requirements
- R1: Slots 0 to `cfg_last` are run in increasing index order. During a slot's frame, only the select line whose index is stored in the slot's select field is low. At most one line of `ss_n` is ever low, and the lines do not change during a frame.
- R2: With no frame in progress, `sclk` rests at the polarity level (`cfg_cpol`, latched at start). With phase 0, both sides sample on the first (leading) clock edge of each bit and change data on the second. With phase 1, data changes on the leading edge and is sampled on the trailing edge.
- R3: The length field holds the bit count minus one, so 0 means 1 bit and 15 means 16 bits. A frame has exactly twice the bit count in clock edges. It sends the low bit-count bits of the transmit word, most significant first, and the upper bits of the word are not sent.
- R4: At the end of each frame, the bits received are stored in that slot's receive word. The first bit received lands in the most significant used position, and the unused upper bits read as zero. `rd_rx` shows the receive word of slot `rd_idx` combinationally.
- R5: Consecutive `sclk` edges are `cfg_half`+1 system cycles apart. The first edge also comes `cfg_half`+1 cycles after the select line falls.
- R6: Between two frames, all select lines stay high for exactly the slot's delay field plus one system cycles.
- R7: In one-shot mode (`cfg_wrap`=0), `busy` falls and `done` rises after the last slot's delay. `done` stays high until the next `start`, and `busy` and `done` are never high together.
- R8: In looping mode (`cfg_wrap`=1), slot 0 follows the last slot with no end. A `stop` pulse ends the run after the current frame and its delay, and `done` then rises.
- R9: After reset, all selects are high, `sclk`, `mosi`, `busy` and `done` are low, and every receive word reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| q_we | input | 1 | Write enable for one queue slot |
| q_widx | input | 3 | Slot written |
| q_wtx | input | 16 | Transmit word |
| q_wsel | input | 2 | Select line index for the slot |
| q_wlen | input | 4 | Bit count minus one |
| q_wgap | input | 8 | Idle delay after the frame (value+1 cycles) |
| rd_idx | input | 3 | Slot whose receive word is shown |
| rd_rx | output | 16 | Receive word of slot `rd_idx` |
| cfg_cpol | input | 1 | Clock idle level |
| cfg_cpha | input | 1 | Clock phase: 0 sample leading edge, 1 sample trailing edge |
| cfg_half | input | 8 | Serial clock half-period minus one, in system cycles |
| cfg_wrap | input | 1 | Looping mode enable |
| cfg_last | input | 3 | Index of the last slot of the run |
| start | input | 1 | Starts a run from slot 0 when idle |
| stop | input | 1 | Ends a running queue after the current frame |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to peripherals |
| miso | input | 1 | Serial data from peripherals |
| ss_n | output | 4 | Active-low peripheral selects |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Sticky completion flag |

## Verification
The timing is counted from the select line falling. The first serial clock edge is due `cfg_half`+1 cycles later, and each further edge follows after the same interval. The select rises `cfg_half`+1 cycles after the last edge, and the next select falls after the delay field plus one cycles. The bench's slave model and monitor work on the falling system clock edge, so they sample each of these intervals half a cycle after the register that changes it. Receive words are read back only after `done` has risen. At that point every write-back has been registered, and the read path adds no cycle.

// File: rtl/spi_queue_master.sv
module spi_queue_master #(
  parameter int DEPTH = 8,
  parameter int WMAX  = 16,
  parameter int NCS   = 4,
  parameter int DIVW  = 8,
  parameter int GAPW  = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       q_we,
  input  logic [$clog2(DEPTH)-1:0]   q_widx,
  input  logic [WMAX-1:0]            q_wtx,
  input  logic [$clog2(NCS)-1:0]     q_wsel,
  input  logic [$clog2(WMAX)-1:0]    q_wlen,
  input  logic [GAPW-1:0]            q_wgap,
  input  logic [$clog2(DEPTH)-1:0]   rd_idx,
  output logic [WMAX-1:0]            rd_rx,
  input  logic                       cfg_cpol,
  input  logic                       cfg_cpha,
  input  logic [DIVW-1:0]            cfg_half,
  input  logic                       cfg_wrap,
  input  logic [$clog2(DEPTH)-1:0]   cfg_last,
  input  logic                       start,
  input  logic                       stop,
  output logic                       sclk,
  output logic                       mosi,
  input  logic                       miso,
  output logic [NCS-1:0]             ss_n,
  output logic                       busy,
  output logic                       done
);
  localparam int IW = $clog2(DEPTH);
  localparam int LW = $clog2(WMAX);
  localparam int CW = $clog2(NCS);
  localparam int EW = LW + 2;
  localparam logic [LW-1:0] LMAX = LW'(WMAX - 1);

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_TAIL, S_GAP} st_t;
  st_t state;

  logic [WMAX-1:0] tx_mem  [DEPTH];
  logic [WMAX-1:0] rx_mem  [DEPTH];
  logic [CW-1:0]   sel_mem [DEPTH];
  logic [LW-1:0]   len_mem [DEPTH];
  logic [GAPW-1:0] gap_mem [DEPTH];

  logic [IW-1:0]   ptr, last_q;
  logic [CW-1:0]   cur_sel;
  logic [LW-1:0]   cur_len;
  logic [GAPW-1:0] cur_gap, gcnt;
  logic [DIVW-1:0] half_q, timer;
  logic [EW-1:0]   ecnt;
  logic [WMAX-1:0] sh, rx_sh;
  logic            cpol_q, cpha_q, wrap_q, stop_req, sclk_r, done_r;

  logic            framing, tick, samp, finish, load_en;
  logic [EW-1:0]   e_nx, last_e;
  logic [IW-1:0]   load_idx;

  assign framing  = (state == S_XFER) || (state == S_TAIL);
  assign tick     = (timer == half_q);
  assign e_nx     = ecnt + EW'(1);
  assign samp     = e_nx[0] ^ cpha_q;
  assign last_e   = (EW'(cur_len) + EW'(1)) << 1;
  assign finish   = stop_req || ((ptr == last_q) && !wrap_q);
  assign load_en  = ((state == S_IDLE) && start) ||
                    ((state == S_GAP) && (gcnt == '0) && !finish);
  assign load_idx = ((state == S_IDLE) || (ptr == last_q)) ? '0 : ptr + IW'(1);

  assign sclk  = sclk_r;
  assign mosi  = framing ? sh[WMAX-1] : 1'b0;
  assign ss_n  = framing ? ~(NCS'(1) << cur_sel) : '1;
  assign busy  = (state != S_IDLE);
  assign done  = done_r;
  assign rd_rx = rx_mem[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      ptr      <= '0;
      last_q   <= '0;
      cur_sel  <= '0;
      cur_len  <= '0;
      cur_gap  <= '0;
      gcnt     <= '0;
      half_q   <= '0;
      timer    <= '0;
      ecnt     <= '0;
      sh       <= '0;
      rx_sh    <= '0;
      cpol_q   <= 1'b0;
      cpha_q   <= 1'b0;
      wrap_q   <= 1'b0;
      stop_req <= 1'b0;
      sclk_r   <= 1'b0;
      done_r   <= 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
        tx_mem[i]  <= '0;
        rx_mem[i]  <= '0;
        sel_mem[i] <= '0;
        len_mem[i] <= '0;
        gap_mem[i] <= '0;
      end
    end else begin
      if (q_we) begin
        tx_mem[q_widx]  <= q_wtx;
        sel_mem[q_widx] <= q_wsel;
        len_mem[q_widx] <= q_wlen;
        gap_mem[q_widx] <= q_wgap;
      end

      if (busy && stop) stop_req <= 1'b1;

      if (load_en) begin
        ptr     <= load_idx;
        cur_sel <= sel_mem[load_idx];
        cur_len <= len_mem[load_idx];
        cur_gap <= gap_mem[load_idx];
        sh      <= tx_mem[load_idx] << (LMAX - len_mem[load_idx]);
        rx_sh   <= '0;
        ecnt    <= '0;
        timer   <= '0;
        state   <= S_XFER;
      end

      case (state)
        S_IDLE: begin
          sclk_r <= cfg_cpol;
          if (start) begin
            cpol_q   <= cfg_cpol;
            cpha_q   <= cfg_cpha;
            half_q   <= cfg_half;
            wrap_q   <= cfg_wrap;
            last_q   <= cfg_last;
            stop_req <= 1'b0;
            done_r   <= 1'b0;
          end
        end
        S_XFER: begin
          if (tick) begin
            timer  <= '0;
            sclk_r <= ~sclk_r;
            ecnt   <= e_nx;
            if (samp) rx_sh <= {rx_sh[WMAX-2:0], miso};
            else if (ecnt != '0) sh <= {sh[WMAX-2:0], 1'b0};
            if (e_nx == last_e) state <= S_TAIL;
          end else begin
            timer <= timer + DIVW'(1);
          end
        end
        S_TAIL: begin
          if (tick) begin
            rx_mem[ptr] <= rx_sh;
            timer       <= '0;
            gcnt        <= cur_gap;
            state       <= S_GAP;
          end else begin
            timer <= timer + DIVW'(1);
          end
        end
        S_GAP: begin
          if (gcnt != '0) begin
            gcnt <= gcnt - GAPW'(1);
          end else if (finish) begin
            state  <= S_IDLE;
            done_r <= 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R1: one select at most, and it holds for a whole frame
  p_one_sel_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~ss_n));
  p_sel_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_XFER) |=> $stable(ss_n));
  // R2: between frames the clock rests at the latched polarity
  p_gap_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_GAP) |-> (sclk == cpol_q && ss_n == '1));
  // R5: the clock only moves when the half-period timer expires
  p_half_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_XFER && timer != half_q) |=> $stable(sclk));
  // R7: completion flag is sticky and exclusive with busy
  p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);
  p_busy_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done);
  // R8: looping mode keeps running past the last slot
  p_wrap_go_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_GAP && gcnt == '0 && wrap_q && !stop_req && !stop) |=> busy);
endmodule

// File: tb/test_spi_queue_master.sv
module test_spi_queue_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        q_we = 1'b0;
  logic [2:0]  q_widx = '0;
  logic [15:0] q_wtx = '0;
  logic [1:0]  q_wsel = '0;
  logic [3:0]  q_wlen = '0;
  logic [7:0]  q_wgap = '0;
  logic [2:0]  rd_idx = '0;
  logic [15:0] rd_rx;
  logic        cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_wrap = 1'b0;
  logic [7:0]  cfg_half = '0;
  logic [2:0]  cfg_last = '0;
  logic        start = 1'b0, stop = 1'b0;
  logic        sclk, mosi, busy, done;
  logic        miso_r = 1'b0;
  logic [3:0]  ss_n;

  always #5 clk = ~clk;

  spi_queue_master i_spi_queue_master (
    .clk(clk), .rst_n(rst_n), .q_we(q_we), .q_widx(q_widx), .q_wtx(q_wtx),
    .q_wsel(q_wsel), .q_wlen(q_wlen), .q_wgap(q_wgap), .rd_idx(rd_idx),
    .rd_rx(rd_rx), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .cfg_half(cfg_half), .cfg_wrap(cfg_wrap), .cfg_last(cfg_last),
    .start(start), .stop(stop), .sclk(sclk), .mosi(mosi), .miso(miso_r),
    .ss_n(ss_n), .busy(busy), .done(done));

  // slave model and bus monitor, both on the falling system edge
  logic [15:0] sl_word [4];
  int          sl_len  [4];
  logic [15:0] f_cap   [16];
  int f_sel[16], f_edges[16], f_gap[16], f_imin[16], f_imax[16];
  int fc = 0, cur = 0, ic = 0, imin = 0, imax = 0, edges = 0, bptr = 0, hc = 0;
  logic [15:0] cap = '0;
  logic [3:0]  prev_ss = 4'hF;
  logic        prev_sclk = 1'b0;

  always @(negedge clk) begin
    if (prev_ss == 4'hF && ss_n != 4'hF) begin
      for (int k = 0; k < 4; k++) if (!ss_n[k]) cur = k;
      f_sel[fc % 16] = cur;
      f_gap[fc % 16] = hc;
      ic = 0; imin = 1000000; imax = 0; edges = 0; cap = '0;
      bptr = sl_len[cur] - 1;
      if (!cfg_cpha) begin miso_r = sl_word[cur][bptr]; bptr--; end
    end else if (ss_n != 4'hF) begin
      ic++;
      if (sclk != prev_sclk) begin
        if (ic < imin) imin = ic;
        if (ic > imax) imax = ic;
        ic = 0;
        edges++;
        if ((sclk != cfg_cpol) ^ cfg_cpha) cap = {cap[14:0], mosi};
        else if (bptr >= 0) begin miso_r = sl_word[cur][bptr]; bptr--; end
      end
    end else begin
      if (prev_ss != 4'hF) begin
        f_cap[fc % 16] = cap; f_edges[fc % 16] = edges;
        f_imin[fc % 16] = imin; f_imax[fc % 16] = imax;
        fc++; hc = 1;
      end else hc++;
    end
    prev_ss = ss_n;
    prev_sclk = sclk;
  end

  int checks = 0, fails = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] msk(int n);
    return (n >= 16) ? 16'hFFFF : ((16'(1) << n) - 16'(1));
  endfunction

  task automatic put(int idx, logic [15:0] tx, int sel, int len, int gap);
    @(negedge clk);
    q_we = 1'b1; q_widx = 3'(idx); q_wtx = tx;
    q_wsel = 2'(sel); q_wlen = 4'(len); q_wgap = 8'(gap);
    @(negedge clk);
    q_we = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done(string tag);
    int n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    chk(tag, {31'd0, done}, 32'd1);
  endtask

  task automatic read_rx(int idx, output logic [15:0] v);
    @(negedge clk); rd_idx = 3'(idx); #1 v = rd_rx;
  endtask

  // {cpol, cpha, half[7:0], len-1[3:0], tx[15:0], slave word[15:0]}
  localparam logic [45:0] VEC [6] = '{
    {1'b0, 1'b0, 8'd1, 4'd7,  16'h00A5, 16'h003C},
    {1'b0, 1'b1, 8'd0, 4'd15, 16'hBEEF, 16'h1234},
    {1'b1, 1'b0, 8'd2, 4'd0,  16'hFFFE, 16'h0001},
    {1'b1, 1'b1, 8'd3, 4'd4,  16'h0013, 16'hFFEA},
    {1'b0, 1'b0, 8'd0, 4'd11, 16'h0ABC, 16'h0F0F},
    {1'b1, 1'b1, 8'd0, 4'd15, 16'h8001, 16'hC003}
  };

  task automatic run_tests();
    logic [15:0] v;
    int base, n;
    for (int k = 0; k < 4; k++) begin sl_word[k] = '0; sl_len[k] = 1; end
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 ss_n", {28'd0, ss_n}, 32'hF);
    chk("R9 sclk", {31'd0, sclk}, 32'd0);
    chk("R9 mosi", {31'd0, mosi}, 32'd0);
    chk("R9 busy/done", {30'd0, busy, done}, 32'd0);
    read_rx(3, v);
    chk("R9 rx word", {16'd0, v}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // vector table: one slot per run, every mode
    for (int i = 0; i < 6; i++) begin
      automatic logic [45:0] w = VEC[i];
      automatic int L = int'(w[35:32]) + 1;
      automatic int sel = i % 4;
      cfg_cpol = w[45]; cfg_cpha = w[44]; cfg_half = w[43:36];
      cfg_wrap = 1'b0; cfg_last = 3'd0;
      sl_word[sel] = w[15:0]; sl_len[sel] = L;
      put(0, w[31:16], sel, int'(w[35:32]), 2);
      repeat (2) @(negedge clk);
      chk($sformatf("R2 idle level v%0d", i), {31'd0, sclk}, {31'd0, w[45]});
      base = fc;
      pulse_start();
      wait_done($sformatf("R7 done v%0d", i));
      chk($sformatf("R7 one frame v%0d", i), 32'(fc - base), 32'd1);
      chk($sformatf("R1 select v%0d", i), 32'(f_sel[base % 16]), 32'(sel));
      chk($sformatf("R3 mosi bits v%0d", i), {16'd0, f_cap[base % 16] & msk(L)},
          {16'd0, w[31:16] & msk(L)});
      chk($sformatf("R3 edge count v%0d", i), 32'(f_edges[base % 16]), 32'(2 * L));
      chk($sformatf("R5 min half v%0d", i), 32'(f_imin[base % 16]), 32'(w[43:36]) + 1);
      chk($sformatf("R5 max half v%0d", i), 32'(f_imax[base % 16]), 32'(w[43:36]) + 1);
      read_rx(0, v);
      chk($sformatf("R4 rx word v%0d", i), {16'd0, v}, {16'd0, w[15:0] & msk(L)});
      chk($sformatf("R2 level after v%0d", i), {31'd0, sclk}, {31'd0, w[45]});
    end

    // R1 R6 R7: three slots, distinct selects and delays
    cfg_cpol = 1'b0; cfg_cpha = 1'b0; cfg_half = 8'd0; cfg_wrap = 1'b0; cfg_last = 3'd2;
    sl_word[2] = 16'h00C3; sl_len[2] = 8;
    sl_word[0] = 16'h0006; sl_len[0] = 4;
    sl_word[3] = 16'hACE1; sl_len[3] = 16;
    put(0, 16'h005A, 2, 7, 3);
    put(1, 16'h0009, 0, 3, 0);
    put(2, 16'h1357, 3, 15, 5);
    base = fc;
    pulse_start();
    wait_done("R7 done multi");
    chk("R1 frame count", 32'(fc - base), 32'd3);
    chk("R1 order slot0", 32'(f_sel[base % 16]), 32'd2);
    chk("R1 order slot1", 32'(f_sel[(base + 1) % 16]), 32'd0);
    chk("R1 order slot2", 32'(f_sel[(base + 2) % 16]), 32'd3);
    chk("R6 delay 3", 32'(f_gap[(base + 1) % 16]), 32'd4);
    chk("R6 delay 0", 32'(f_gap[(base + 2) % 16]), 32'd1);
    chk("R3 mosi slot2", {16'd0, f_cap[(base + 2) % 16]}, 32'h1357);
    read_rx(0, v); chk("R4 slot0 rx", {16'd0, v}, 32'h00C3);
    read_rx(1, v); chk("R4 slot1 rx", {16'd0, v}, 32'h0006);
    read_rx(2, v); chk("R4 slot2 rx", {16'd0, v}, 32'hACE1);
    repeat (5) @(negedge clk);
    chk("R7 done sticky", {30'd0, busy, done}, 32'd1);
    chk("R1 selects idle", {28'd0, ss_n}, 32'hF);

    // R8: looping mode with a stop request
    cfg_wrap = 1'b1; cfg_last = 3'd1;
    sl_word[1] = 16'h0005; sl_len[1] = 4;
    sl_word[2] = 16'h000A; sl_len[2] = 4;
    put(0, 16'h0003, 1, 3, 1);
    put(1, 16'h000C, 2, 3, 1);
    base = fc;
    pulse_start();
    @(negedge clk);
    chk("R7 done cleared by start", {30'd0, busy, done}, 32'd2);
    n = 0;
    while (fc - base < 5 && n < 20000) begin @(negedge clk); n++; end
    chk("R8 looping frames", {31'd0, (fc - base >= 5)}, 32'd1);
    chk("R8 still busy", {30'd0, busy, done}, 32'd2);
    chk("R8 third frame is slot0", 32'(f_sel[(base + 2) % 16]), 32'd1);
    chk("R8 fourth frame is slot1", 32'(f_sel[(base + 3) % 16]), 32'd2);
    chk("R8 fifth frame is slot0", 32'(f_sel[(base + 4) % 16]), 32'd1);
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    wait_done("R8 done after stop");
    n = fc;
    repeat (40) @(negedge clk);
    chk("R8 no frames after stop", 32'(fc), 32'(n));
    chk("R8 idle after stop", {28'd0, ss_n}, 32'hF);
    read_rx(1, v); chk("R4 looping rx slot1", {16'd0, v}, 32'h000A);
  endtask

  initial begin
    logic wd = 1'b0;
    fork
      run_tests();
      begin repeat (150000) @(posedge clk); wd = 1'b1; end
    join_any
    disable fork;
    if (wd) begin
      checks++; fails++;
      $display("FAIL watchdog: got expired expected finished");
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule